// File: doc/BRIEF.md
# Five-Step Sequential Load/Store Processor

This block is a 32-bit load/store processor that executes one instruction at a time. Each instruction takes five clock cycles, one for each step in a fixed order. Step 0 fetches the instruction word and forms the next sequential address. Step 1 reads two source registers and sign-extends the immediate. Step 2 runs the ALU to produce a result, an effective address or a branch target. Step 3 accesses data memory and commits the program counter. Step 4 writes the register file. The working values are held in internal registers from one step to the next: the instruction word, the next address, the two operands, the immediate, the ALU result, the zero flag and the loaded word.

The instruction store and the data store are internal word arrays. Both are filled through a load port while reset is held. Progress is visible at the ports. The current step and the program counter are outputs. A free-running cycle counter starts at zero after reset. One strobe with register index and value marks each register-file write, and another strobe with address and value marks each store.

Top module: `mc_rcore`

## Requirements
- R1: The step output goes 0,1,2,3,4 and then back to 0, advancing once per clock. `cycle_cnt` is 0 in the first cycle after reset and increases by one every clock. The n-th instruction (counting from 0) is in step 4 when `cycle_cnt` equals 5n+4.
- R2: The PC is 0 after reset. It changes only on the clock edge that ends step 3. For an instruction that does not branch, the new PC is the old PC plus 4. Instruction words are indexed by PC bits above bit 1.
- R3: The instruction fields are: opcode in bits 31:26, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, function code in bits 5:0, and a 16-bit immediate in bits 15:0 that is always sign-extended.
- R4: Opcode 0x00 selects a register-register operation on rs and rt, with the result written to rd. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor and 0x2A signed set-less-than.
- R5: The opcodes 0x08 add, 0x0C and, 0x0D or, 0x0E xor and 0x0A signed set-less-than combine rs with the sign-extended immediate and write the result to rt.
- R6: Opcode 0x23 loads the data word at address rs+imm into rt. Data words are indexed by address bits above bit 1.
- R7: Opcode 0x2B stores rt at address rs+imm. The store strobe is high only during step 3 of that instruction.
- R8: Opcode 0x04 branches if rs equals zero. The target is the next address plus the immediate shifted left by two. A branch that is not taken continues at the next address.
- R9: Register 0 always reads as zero. A write addressed to it produces no write strobe.
- R10: An opcode or function code not listed above still takes five cycles. It writes nothing, stores nothing and advances the PC by 4.
- R11: While reset is high, a load-port write sets one word of the instruction store (`ld_dmem`=0) or the data store (`ld_dmem`=1).
- R12: While reset is held, the step output is 0, the PC and cycle count are 0, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write strobe, honoured during reset |
| ld_dmem | input | 1 | Load-port target: 0 instruction store, 1 data store |
| ld_addr | input | log2(MEM_WORDS) | Load-port word index |
| ld_data | input | 32 | Load-port word |
| stage | output | 3 | Current step (0..4) |
| pc | output | 32 | Program counter |
| cycle_cnt | output | 32 | Clocks since reset |
| wb_en | output | 1 | Register-file write in this cycle |
| wb_addr | output | 5 | Register written |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | Data-store write in this cycle |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store value |

## Verification
The bench builds the block with the default MEM_WORDS of 64, so each store holds 64 words indexed by a 6-bit field. With that size, a 25-word program covers every operation and both branch outcomes. The program also includes an undefined opcode, writes to register 0, and loads from preloaded data words at distinct indices. A backward self-branch at the end keeps the block in a loop for the last retirements, which checks the PC commit rule repeatedly.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEMORY = 3'd3,
        ST_WRITE  = 3'd4
    } stage_e;

    typedef enum logic [2:0] {
        ICL_NOP, ICL_REGREG, ICL_REGIMM, ICL_LOAD, ICL_STORE, ICL_BRZ
    } iclass_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
    } alu_e;

    typedef struct packed {
        iclass_e cls;
        alu_e    op;
    } dec_t;

    localparam logic [5:0] OPC_REGREG = 6'h00;
    localparam logic [5:0] OPC_BRZ    = 6'h04;
    localparam logic [5:0] OPC_ADDI   = 6'h08;
    localparam logic [5:0] OPC_SLTI   = 6'h0A;
    localparam logic [5:0] OPC_ANDI   = 6'h0C;
    localparam logic [5:0] OPC_ORI    = 6'h0D;
    localparam logic [5:0] OPC_XORI   = 6'h0E;
    localparam logic [5:0] OPC_LOAD   = 6'h23;
    localparam logic [5:0] OPC_STORE  = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    function automatic logic [4:0] f_rs(input logic [31:0] w);
        return w[25:21];
    endfunction

    function automatic logic [4:0] f_rt(input logic [31:0] w);
        return w[20:16];
    endfunction

    function automatic logic [4:0] f_rd(input logic [31:0] w);
        return w[15:11];
    endfunction

    function automatic logic [31:0] sext16(input logic [31:0] w);
        return {{16{w[15]}}, w[15:0]};
    endfunction

    function automatic stage_e stage_after(input stage_e s);
        case (s)
            ST_FETCH:  return ST_DECODE;
            ST_DECODE: return ST_EXEC;
            ST_EXEC:   return ST_MEMORY;
            ST_MEMORY: return ST_WRITE;
            default:   return ST_FETCH;
        endcase
    endfunction

    function automatic dec_t decode(input logic [31:0] w);
        dec_t d;
        d.cls = ICL_NOP;
        d.op  = ALU_ADD;
        case (w[31:26])
            OPC_REGREG: begin
                d.cls = ICL_REGREG;
                case (w[5:0])
                    FN_ADD:  d.op = ALU_ADD;
                    FN_SUB:  d.op = ALU_SUB;
                    FN_AND:  d.op = ALU_AND;
                    FN_OR:   d.op = ALU_OR;
                    FN_XOR:  d.op = ALU_XOR;
                    FN_SLT:  d.op = ALU_SLT;
                    default: d.cls = ICL_NOP;
                endcase
            end
            OPC_ADDI:  begin d.cls = ICL_REGIMM; d.op = ALU_ADD; end
            OPC_SLTI:  begin d.cls = ICL_REGIMM; d.op = ALU_SLT; end
            OPC_ANDI:  begin d.cls = ICL_REGIMM; d.op = ALU_AND; end
            OPC_ORI:   begin d.cls = ICL_REGIMM; d.op = ALU_OR;  end
            OPC_XORI:  begin d.cls = ICL_REGIMM; d.op = ALU_XOR; end
            OPC_LOAD:  d.cls = ICL_LOAD;
            OPC_STORE: d.cls = ICL_STORE;
            OPC_BRZ:   d.cls = ICL_BRZ;
            default:   d.cls = ICL_NOP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rcore_seq.sv
module rcore_seq
    import rcore_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    output stage_e           stage,
    output logic [CNT_W-1:0] cycle_cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= ST_FETCH;
            cycle_cnt <= '0;
        end else begin
            stage     <= stage_after(stage);
            cycle_cnt <= cycle_cnt + 1'b1;
        end
    end

    assert_stage_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_WRITE) |=> (stage == ST_FETCH));

    assert_stage_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_FETCH) |=> (stage == ST_DECODE));

    assert_cycle_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cycle_cnt == $past(cycle_cnt) + 1'b1));

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
    parameter int NREGS = 32,
    parameter int XLEN  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREGS)-1:0] ra_addr,
    output logic [XLEN-1:0]          ra_data,
    input  logic [$clog2(NREGS)-1:0] rb_addr,
    output logic [XLEN-1:0]          rb_data,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [XLEN-1:0]          wdata
);

    logic [XLEN-1:0] regs [NREGS];

    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_reg
            if (i == 0) begin : g_zero
                always_ff @(posedge clk) regs[i] <= '0;
            end else begin : g_live
                always_ff @(posedge clk) begin
                    if (rst)
                        regs[i] <= '0;
                    else if (we && waddr == i)
                        regs[i] <= wdata;
                end
            end
        end
    endgenerate

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

    assert_zero_read_R9: assert property (@(posedge clk) disable iff (rst)
        (ra_addr == '0) |-> (ra_data == '0));

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_e            op,
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    output logic [XLEN-1:0] res
);

    always_comb begin
        case (op)
            ALU_ADD: res = x + y;
            ALU_SUB: res = x - y;
            ALU_AND: res = x & y;
            ALU_OR:  res = x | y;
            ALU_XOR: res = x ^ y;
            ALU_SLT: res = {{(XLEN-1){1'b0}}, $signed(x) < $signed(y)};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/rcore_wordmem.sv
module rcore_wordmem #(
    parameter int WORDS = 64,
    parameter int XLEN  = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mc_rcore.sv
module mc_rcore
    import rcore_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int AW       = $clog2(MEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic          ld_dmem,
    input  logic [AW-1:0] ld_addr,
    input  logic [31:0]   ld_data,
    output logic [2:0]    stage,
    output logic [31:0]   pc,
    output logic [31:0]   cycle_cnt,
    output logic          wb_en,
    output logic [4:0]    wb_addr,
    output logic [31:0]   wb_data,
    output logic          st_en,
    output logic [31:0]   st_addr,
    output logic [31:0]   st_data
);

    localparam int XLEN = 32;

    stage_e          stg;
    logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
    logic            cond_q;
    dec_t            dec;
    logic [XLEN-1:0] rf_a, rf_b, imem_rd, dmem_rd, alu_x, alu_y, alu_res;
    alu_e            alu_op;
    logic            imem_we, dmem_we;
    logic [AW-1:0]   dmem_waddr;
    logic [XLEN-1:0] dmem_wdata;
    logic [4:0]      dest;
    logic            writes_reg;

    rcore_seq #(.CNT_W(32)) u_seq (
        .clk(clk), .rst(rst), .stage(stg), .cycle_cnt(cycle_cnt)
    );

    assign dec = decode(ir_q);

    rcore_regfile #(.NREGS(32), .XLEN(XLEN)) u_rf (
        .clk(clk), .rst(rst),
        .ra_addr(f_rs(ir_q)), .ra_data(rf_a),
        .rb_addr(f_rt(ir_q)), .rb_data(rf_b),
        .we(wb_en), .waddr(wb_addr), .wdata(wb_data)
    );

    always_comb begin
        alu_x  = a_q;
        alu_y  = imm_q;
        alu_op = ALU_ADD;
        case (dec.cls)
            ICL_REGREG: begin alu_y = b_q; alu_op = dec.op; end
            ICL_REGIMM: alu_op = dec.op;
            ICL_BRZ:    begin alu_x = npc_q; alu_y = {imm_q[XLEN-3:0], 2'b00}; end
            default:    ;
        endcase
    end

    rcore_alu #(.XLEN(XLEN)) u_alu (
        .op(alu_op), .x(alu_x), .y(alu_y), .res(alu_res)
    );

    assign imem_we = rst && ld_en && !ld_dmem;

    rcore_wordmem #(.WORDS(MEM_WORDS), .XLEN(XLEN)) u_imem (
        .clk(clk), .we(imem_we), .waddr(ld_addr), .wdata(ld_data),
        .raddr(pc_q[AW+1:2]), .rdata(imem_rd)
    );

    always_comb begin
        if (rst) begin
            dmem_we    = ld_en && ld_dmem;
            dmem_waddr = ld_addr;
            dmem_wdata = ld_data;
        end else begin
            dmem_we    = st_en;
            dmem_waddr = alu_q[AW+1:2];
            dmem_wdata = b_q;
        end
    end

    rcore_wordmem #(.WORDS(MEM_WORDS), .XLEN(XLEN)) u_dmem (
        .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
        .raddr(alu_q[AW+1:2]), .rdata(dmem_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            npc_q  <= '0;
            ir_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
            imm_q  <= '0;
            alu_q  <= '0;
            lmd_q  <= '0;
            cond_q <= 1'b0;
        end else begin
            case (stg)
                ST_FETCH: begin
                    ir_q  <= imem_rd;
                    npc_q <= pc_q + 32'd4;
                end
                ST_DECODE: begin
                    a_q   <= rf_a;
                    b_q   <= rf_b;
                    imm_q <= sext16(ir_q);
                end
                ST_EXEC: begin
                    alu_q  <= alu_res;
                    cond_q <= (a_q == '0);
                end
                ST_MEMORY: begin
                    pc_q <= (dec.cls == ICL_BRZ && cond_q) ? alu_q : npc_q;
                    if (dec.cls == ICL_LOAD)
                        lmd_q <= dmem_rd;
                end
                default: ;
            endcase
        end
    end

    assign writes_reg = (dec.cls == ICL_REGREG) || (dec.cls == ICL_REGIMM) ||
                        (dec.cls == ICL_LOAD);
    assign dest       = (dec.cls == ICL_REGREG) ? f_rd(ir_q) : f_rt(ir_q);

    assign stage   = stg;
    assign pc      = pc_q;
    assign wb_en   = !rst && stg == ST_WRITE && writes_reg && dest != 5'd0;
    assign wb_addr = dest;
    assign wb_data = (dec.cls == ICL_LOAD) ? lmd_q : alu_q;
    assign st_en   = !rst && stg == ST_MEMORY && dec.cls == ICL_STORE;
    assign st_addr = alu_q;
    assign st_data = b_q;

    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (stg != ST_MEMORY) |=> $stable(pc_q));

    assert_pc_seq_R2: assert property (@(posedge clk) disable iff (rst)
        (stg == ST_MEMORY && dec.cls != ICL_BRZ) |=> (pc_q == $past(pc_q) + 32'd4));

    assert_store_addr_R7: assert property (@(posedge clk) disable iff (rst)
        st_en |-> (st_addr == a_q + imm_q));

    assert_no_r0_write_R9: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_addr != 5'd0));

    assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (dec.cls == ICL_NOP && stg != ST_FETCH) |-> (!wb_en && !st_en));

endmodule

// File: tb/mc_rcore_test.sv
`timescale 1ns/1ps
module mc_rcore_test;

    localparam int MEMW   = 64;
    localparam int N_INST = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [2:0]  stage;
    logic [31:0] pc, cycle_cnt, wb_data, st_addr, st_data;
    logic        wb_en, st_en;
    logic [4:0]  wb_addr;

    always #4 clk = ~clk;

    mc_rcore #(.MEM_WORDS(MEMW)) uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .stage(stage), .pc(pc),
        .cycle_cnt(cycle_cnt), .wb_en(wb_en), .wb_addr(wb_addr),
        .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
    );

    int checks = 0;
    int fails  = 0;
    int retired = 0;
    bit running = 0;

    logic [31:0] prog [MEMW];
    logic [31:0] dref [MEMW];
    logic [31:0] regs [32];

    logic [4:0]  wbq_reg [$];
    logic [31:0] wbq_dat [$];
    string       wbq_tag [$];
    logic [31:0] stq_adr [$];
    logic [31:0] stq_dat [$];
    logic [31:0] pcq_val [$];
    string       pcq_tag [$];

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    // Driver: reference execution of the program, pushing expected items.
    task automatic drive_expect();
        logic [31:0] p, w, a, b, simm, res, adr, nxt;
        string ptag;
        bit ok;
        p = 0;
        ptag = "R12";
        for (int k = 0; k < 32; k++) regs[k] = 0;
        for (int k = 0; k < N_INST; k++) begin
            pcq_val.push_back(p);
            pcq_tag.push_back(ptag);
            ptag = "R2";
            w = prog[p[7:2]];
            a = regs[w[25:21]];
            b = regs[w[20:16]];
            simm = {{16{w[15]}}, w[15:0]};
            nxt = p + 4;
            ok = 1;
            res = 0;
            case (w[31:26])
                6'h00: begin
                    case (w[5:0])
                        6'h20: res = a + b;
                        6'h22: res = a - b;
                        6'h24: res = a & b;
                        6'h25: res = a | b;
                        6'h26: res = a ^ b;
                        6'h2A: res = ($signed(a) < $signed(b)) ? 1 : 0;
                        default: ok = 0;
                    endcase
                    if (!ok) ptag = "R10";
                    else if (w[15:11] != 0) begin
                        regs[w[15:11]] = res;
                        wbq_reg.push_back(w[15:11]);
                        wbq_dat.push_back(res);
                        wbq_tag.push_back((w[25:21] == 0 && w[20:16] == 0) ? "R9" : "R3,R4");
                    end
                end
                6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E: begin
                    case (w[31:26])
                        6'h08: res = a + simm;
                        6'h0A: res = ($signed(a) < $signed(simm)) ? 1 : 0;
                        6'h0C: res = a & simm;
                        6'h0D: res = a | simm;
                        default: res = a ^ simm;
                    endcase
                    if (w[20:16] != 0) begin
                        regs[w[20:16]] = res;
                        wbq_reg.push_back(w[20:16]);
                        wbq_dat.push_back(res);
                        wbq_tag.push_back("R5");
                    end else ptag = "R9";
                end
                6'h23: begin
                    adr = a + simm;
                    res = dref[adr[7:2]];
                    if (w[20:16] != 0) begin
                        regs[w[20:16]] = res;
                        wbq_reg.push_back(w[20:16]);
                        wbq_dat.push_back(res);
                        wbq_tag.push_back("R6,R11");
                    end
                end
                6'h2B: begin
                    adr = a + simm;
                    dref[adr[7:2]] = b;
                    stq_adr.push_back(adr);
                    stq_dat.push_back(b);
                end
                6'h04: begin
                    if (a == 0) nxt = p + 4 + {simm[29:0], 2'b00};
                    ptag = "R8";
                end
                default: ptag = "R10";
            endcase
            p = nxt;
        end
    endtask

    // Monitor: compare design events against the scoreboard queues.
    always @(negedge clk) begin
        if (running) begin
            if (stage == 3'd0 && pcq_val.size() > 0)
                check(pcq_tag.pop_front(), pc, pcq_val.pop_front());
            if (stage == 3'd4) begin
                check("R1", cycle_cnt, 32'(5 * retired + 4));
                retired++;
            end
            if (wb_en) begin
                if (wbq_reg.size() == 0) check("R9", {27'd0, wb_addr}, 32'hFFFF_FFFF);
                else begin
                    string t;
                    t = wbq_tag.pop_front();
                    check(t, {27'd0, wb_addr}, {27'd0, wbq_reg.pop_front()});
                    check(t, wb_data, wbq_dat.pop_front());
                end
            end
            if (st_en) begin
                if (stq_adr.size() == 0) check("R7", st_addr, 32'hFFFF_FFFF);
                else begin
                    check("R7", st_addr, stq_adr.pop_front());
                    check("R7", st_data, stq_dat.pop_front());
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < MEMW; k++) begin prog[k] = 32'h0; dref[k] = 32'h0; end
        prog[0]  = enc_i(6'h08, 1, 0, 5);
        prog[1]  = enc_i(6'h08, 2, 0, -3);
        prog[2]  = enc_r(6'h20, 3, 1, 2);
        prog[3]  = enc_r(6'h22, 4, 2, 1);
        prog[4]  = enc_r(6'h24, 5, 1, 2);
        prog[5]  = enc_r(6'h25, 6, 1, 2);
        prog[6]  = enc_r(6'h26, 7, 1, 2);
        prog[7]  = enc_r(6'h2A, 8, 2, 1);
        prog[8]  = enc_r(6'h2A, 9, 1, 2);
        prog[9]  = enc_i(6'h0A, 10, 2, 0);
        prog[10] = enc_i(6'h2B, 4, 0, 8);
        prog[11] = enc_i(6'h23, 11, 0, 8);
        prog[12] = enc_i(6'h23, 12, 0, 0);
        prog[13] = enc_i(6'h23, 18, 1, 7);
        prog[14] = enc_i(6'h08, 0, 0, 7);
        prog[15] = enc_r(6'h20, 13, 0, 0);
        prog[16] = enc_i(6'h04, 0, 1, 5);
        prog[17] = enc_i(6'h04, 0, 0, 2);
        prog[18] = enc_i(6'h08, 14, 0, 1);
        prog[19] = enc_i(6'h08, 14, 0, 2);
        prog[20] = 32'hFC00_0000;
        prog[21] = enc_i(6'h0D, 15, 1, 16'h00F0);
        prog[22] = enc_i(6'h0E, 16, 2, 1);
        prog[23] = enc_i(6'h0C, 17, 2, 16'h00FF);
        prog[24] = enc_i(6'h04, 0, 0, -1);
        dref[0]  = 32'h1234_5678;
        dref[3]  = 32'hCAFE_F00D;

        // preload through the load port while reset is held (R11)
        repeat (2) @(negedge clk);
        for (int k = 0; k < 25; k++) begin
            ld_en = 1; ld_dmem = 0; ld_addr = 6'(k); ld_data = prog[k];
            @(negedge clk);
        end
        ld_dmem = 1; ld_addr = 6'd0; ld_data = dref[0]; @(negedge clk);
        ld_addr = 6'd3; ld_data = dref[3]; @(negedge clk);
        ld_en = 0;

        // reset state (R12)
        check("R12", {29'd0, stage}, 32'd0);
        check("R12", pc, 32'd0);
        check("R12", cycle_cnt, 32'd0);
        check("R12", {31'd0, wb_en}, 32'd0);
        check("R12", {31'd0, st_en}, 32'd0);

        drive_expect();
        running = 1;
        rst = 0;
        while (retired < N_INST) @(negedge clk);
        running = 0;
        check("R2", 32'(pcq_val.size()), 32'd0);
        check("R4", 32'(wbq_reg.size()), 32'd0);
        check("R7", 32'(stq_adr.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1: got %0d expected %0d retirements", retired, N_INST);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule